// File: doc/BRIEF.md
# Masked-Write GPIO Port Bank

This block is a register-mapped general-purpose I/O port of 24 pins, arranged as three banks of eight. Pin p belongs to bank p/8 at bit position p%8. Software reaches it over a byte-wide register bus made of address, write-enable, write-data and read-data ports. Writes take effect on the rising clock edge. Reads are combinational from the addressed register. For each pin the port stores an output data bit, a direction bit, a drive-mode select bit and a drive-mode enable bit. From these it produces an output-enable and an output value for the pad.

Output data is never written directly. A data write is a pair of bytes. The first byte, sent to the even address of the bank's data pair, is held in a staging register. The second byte, sent to the odd address, is a mask. On that second write, each pin whose mask bit is 1 takes its bit from the staged byte, and every other pin keeps its value. Software can therefore change single pins without a read-modify-write.

Each output pin can drive in one of three ways: push-pull, open-drain (drives only low) or open-source (drives only high). A port-hold bit sits in a control register and keeps every bank register at its reset value until software writes it to 0. Reading a bank's even data address returns the pin levels after a two-flop synchroniser, whatever the direction of the pin.

Top module: `gpb_port`

## Requirements
- R1: After `rst_n` has been low for at least one clock edge, the following hold. The port-hold bit (address 0x00, bit 0) reads 1. All `pin_oe` and `pin_out` bits are 0. Every direction, drive-select, drive-enable and output-data register reads 0.
- R2: While the port-hold bit is 1, writes to any bank address (0x10..0x15, 0x20..0x22, 0x30..0x35) change nothing. `pin_oe` and `pin_out` stay 0, and those registers read 0.
- R3: Writing address 0x00 loads bit 0 of the write data into the port-hold bit. When it is set again after a release, all bank registers return to 0 on the next clock edge and stay 0 after it is cleared again.
- R4: A write of byte V to address 0x10+2b stages V for bank b. A following write of mask M to address 0x11+2b sets the bank's output data to (old & ~M) | (V & M). A mask of 0 leaves the data unchanged. Output data changes only on a mask write or a hold. Reading 0x11+2b returns the output data.
- R5: The direction register of bank b is at 0x20+b. Bit 1 makes a pin an output and bit 0 makes it an input. An input pin has `pin_oe` 0.
- R6: The drive-select register of bank b is at 0x30+2b and the drive-enable register is at 0x31+2b. An output pin whose drive-enable bit is 0 is push-pull: `pin_oe` is 1.
- R7: An output pin with drive-enable 1 and drive-select 0 is open-drain: `pin_oe` is 1 only when its data bit is 0.
- R8: An output pin with drive-enable 1 and drive-select 1 is open-source: `pin_oe` is 1 only when its data bit is 1.
- R9: `pin_out` equals the pin's output-data bit in every mode.
- R10: A read of 0x10+2b returns bank b's `pin_in` bits as sampled two clock edges earlier. A change applied between edges appears after the second following edge and not after the first.
- R11: The direction, drive-select and drive-enable registers read back the last value written. Addresses outside the map read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| pin_in | input | 24 | Pad input levels, asynchronous |
| pin_oe | output | 24 | Per-pin output enable |
| pin_out | output | 24 | Per-pin output value |

## Verification
The bench sweeps all sixteen combinations of direction, select, enable and data uniformly across each bank. It then applies mixed per-bit patterns, so that a swapped open-drain and open-source decode, or an input pin left driving, shows at once on `pin_oe`. A long run of value-and-mask pairs, including a zero mask and a full mask, catches a design that loads the mask as data, ignores the staged byte or disturbs unmasked pins. The synchroniser is probed one edge after and two edges after an input change, which exposes a design with one stage or three. The port-hold bit is exercised at reset and after a release, with bus writes that a design ignoring the hold would let through.

// File: rtl/gpb_pkg.sv
// Package gpb_pkg
// Shared register addresses, drive-mode encoding and address helpers for the
// masked-write GPIO port. Assumes at most eight banks so the paired windows
// do not overlap.
package gpb_pkg;

    // Register address bases (byte addresses)
    localparam int A_HOLD = 'h00;   // bit 0: port hold
    localparam int A_DATA = 'h10;   // value at base+2b, mask at base+2b+1
    localparam int A_DIR  = 'h20;   // one byte per bank, consecutive
    localparam int A_MODE = 'h30;   // select at base+2b, enable at base+2b+1

    // Resolved drive style of one pin
    typedef enum logic [1:0] {
        DRV_OFF    = 2'd0,
        DRV_PUSH   = 2'd1,
        DRV_DRAIN  = 2'd2,
        DRV_SOURCE = 2'd3
    } drv_mode_e;

    // True when address a is the mask byte of one of nb banks
    function automatic logic is_mask_addr(input int a, input int nb);
        return (a >= A_DATA) && (a < A_DATA + 2 * nb) && (a % 2 == 1);
    endfunction

endpackage

// File: rtl/gpb_sync.sv
// Module gpb_sync
// Two-stage synchroniser for asynchronous pad inputs. Assumes each bit is
// independent; no multi-bit coherence is promised.
module gpb_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    // Shift pad levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpb_bank.sv
// Module gpb_bank
// Register set of one bank: staging byte, output data, direction, drive
// select and drive enable. Assumes write strobes are already decoded and
// gated; clr forces every register back to its reset value.
module gpb_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         we_val,
    input  logic         we_msk,
    input  logic         we_dir,
    input  logic         we_sel,
    input  logic         we_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dat_q,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] sel_q,
    output logic [W-1:0] en_q
);

    logic [W-1:0] stage_q;

    // Hold the value byte until its mask byte arrives
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            stage_q <= '0;
        else if (we_val)
            stage_q <= wdata;
    end

    // Merge staged value into output data under the mask
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            dat_q <= '0;
        else if (we_msk)
            dat_q <= (dat_q & ~wdata) | (stage_q & wdata);
    end

    // Direction and drive-mode configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dir_q <= '0;
            sel_q <= '0;
            en_q  <= '0;
        end else begin
            if (we_dir) dir_q <= wdata;
            if (we_sel) sel_q <= wdata;
            if (we_en)  en_q  <= wdata;
        end
    end

endmodule

// File: rtl/gpb_drive.sv
// Module gpb_drive
// Per-pin pad control: resolves direction and drive mode into an output
// enable and output value. Purely combinational; assumes registered inputs.
module gpb_drive
    import gpb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] en,
    input  logic [W-1:0] sel,
    input  logic [W-1:0] dat,
    output logic [W-1:0] oe,
    output logic [W-1:0] out
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        drv_mode_e mode;

        // Classify the pin's drive style
        always_comb begin
            if (!dir[i])
                mode = DRV_OFF;
            else if (!en[i])
                mode = DRV_PUSH;
            else if (!sel[i])
                mode = DRV_DRAIN;
            else
                mode = DRV_SOURCE;
        end

        // Produce the pad enable from the style and data bit
        always_comb begin
            case (mode)
                DRV_PUSH:   oe[i] = 1'b1;
                DRV_DRAIN:  oe[i] = ~dat[i];
                DRV_SOURCE: oe[i] = dat[i];
                default:    oe[i] = 1'b0;
            endcase
        end

        assign out[i] = dat[i];
    end

endmodule

// File: rtl/gpb_port.sv
// Module gpb_port
// Top of the masked-write GPIO port: bus decode, port-hold control, one
// register bank and pad driver per bank, input synchroniser and read mux.
// Assumes a single-cycle write strobe and a combinational read path.
module gpb_port
    import gpb_pkg::*;
#(
    parameter  int NUM_BANKS = 3,
    parameter  int BANK_W    = 8,
    parameter  int ADDR_W    = 8,
    localparam int NPINS     = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_out
);

    logic             hold_q;
    logic             wr_ok;
    int               addr_i;
    logic [NPINS-1:0] sync_v;
    logic [NPINS-1:0] dat_v;
    logic [NPINS-1:0] dir_v;
    logic [NPINS-1:0] sel_v;
    logic [NPINS-1:0] en_v;

    assign addr_i = int'(bus_addr);
    assign wr_ok  = bus_we && !hold_q;

    // Port-hold bit: set by reset, changed only through its own address
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b1;
        else if (bus_we && addr_i == A_HOLD)
            hold_q <= bus_wdata[0];
    end

    gpb_sync #(.W(NPINS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_v)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic we_val, we_msk, we_dir, we_sel, we_en;

        assign we_val = wr_ok && (addr_i == A_DATA + 2 * b);
        assign we_msk = wr_ok && (addr_i == A_DATA + 2 * b + 1);
        assign we_dir = wr_ok && (addr_i == A_DIR + b);
        assign we_sel = wr_ok && (addr_i == A_MODE + 2 * b);
        assign we_en  = wr_ok && (addr_i == A_MODE + 2 * b + 1);

        gpb_bank #(.W(BANK_W)) i_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (hold_q),
            .we_val (we_val),
            .we_msk (we_msk),
            .we_dir (we_dir),
            .we_sel (we_sel),
            .we_en  (we_en),
            .wdata  (bus_wdata),
            .dat_q  (dat_v[b*BANK_W +: BANK_W]),
            .dir_q  (dir_v[b*BANK_W +: BANK_W]),
            .sel_q  (sel_v[b*BANK_W +: BANK_W]),
            .en_q   (en_v[b*BANK_W +: BANK_W])
        );

        gpb_drive #(.W(BANK_W)) i_drive (
            .dir (dir_v[b*BANK_W +: BANK_W]),
            .en  (en_v[b*BANK_W +: BANK_W]),
            .sel (sel_v[b*BANK_W +: BANK_W]),
            .dat (dat_v[b*BANK_W +: BANK_W]),
            .oe  (pin_oe[b*BANK_W +: BANK_W]),
            .out (pin_out[b*BANK_W +: BANK_W])
        );
    end

    // Select the addressed register onto the read bus
    always_comb begin
        bus_rdata = '0;
        if (addr_i == A_HOLD)
            bus_rdata = BANK_W'(hold_q);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr_i == A_DATA + 2 * b)     bus_rdata = sync_v[b*BANK_W +: BANK_W];
            if (addr_i == A_DATA + 2 * b + 1) bus_rdata = dat_v[b*BANK_W +: BANK_W];
            if (addr_i == A_DIR + b)          bus_rdata = dir_v[b*BANK_W +: BANK_W];
            if (addr_i == A_MODE + 2 * b)     bus_rdata = sel_v[b*BANK_W +: BANK_W];
            if (addr_i == A_MODE + 2 * b + 1) bus_rdata = en_v[b*BANK_W +: BANK_W];
        end
    end

endmodule

// File: rtl/gpb_port_chk.sv
// Module gpb_port_chk
// Property checker for gpb_port, bound to every instance below. Observes
// the bank registers and the pad outputs they drive.
module gpb_port_chk
    import gpb_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int NPINS     = 24,
    parameter int ADDR_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              hold,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  dir_v,
    input logic [NPINS-1:0]  en_v,
    input logic [NPINS-1:0]  sel_v,
    input logic [NPINS-1:0]  dat_v
);

    logic mask_wr;
    logic hold_wr;

    always_comb begin
        mask_wr = bus_we && is_mask_addr(int'(bus_addr), NUM_BANKS);
        hold_wr = bus_we && (int'(bus_addr) == A_HOLD);
    end

    // R2: once hold has been in force for a cycle, no pad is driven
    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold) && hold) |-> (pin_oe == '0));

    // R4: output data moves only on a mask write or a hold
    p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !hold_wr && !mask_wr) |=> $stable(dat_v));

    // R5: an input pin never drives
    p_input_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_v & pin_oe) == '0));

    // R6: a push-pull output always drives
    p_push_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_v & ~en_v & ~pin_oe) == '0));

    // R7: open-drain never drives while its data bit is 1
    p_drain_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_v & en_v & ~sel_v & dat_v & pin_oe) == '0));

    // R8: open-source never drives while its data bit is 0
    p_source_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_v & en_v & sel_v & ~dat_v & pin_oe) == '0));

endmodule

bind gpb_port gpb_port_chk #(
    .NUM_BANKS (NUM_BANKS),
    .NPINS     (NPINS),
    .ADDR_W    (ADDR_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .hold     (hold_q),
    .pin_oe   (pin_oe),
    .dir_v    (dir_v),
    .en_v     (en_v),
    .sel_v    (sel_v),
    .dat_v    (dat_v)
);

// File: tb/test_gpb_port.sv
// Bench for gpb_port: sweeps drive modes, masked writes, synchroniser latency
// and the port-hold bit, with expected values worked out arithmetically.
module test_gpb_port;

    localparam int AH = 'h00;
    localparam int AD = 'h10;
    localparam int AR = 'h20;
    localparam int AM = 'h30;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_we;
    logic [7:0]  bus_addr;
    logic [7:0]  bus_wdata;
    wire  [7:0]  bus_rdata;
    logic [23:0] pin_in;
    wire  [23:0] pin_oe;
    wire  [23:0] pin_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    gpb_port i_gpb_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = 8'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        bus_addr = 8'(a);
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] exp_oe(input logic [7:0] d, input logic [7:0] e,
                                          input logic [7:0] s, input logic [7:0] v);
        return d & (~e | (~s & ~v) | (s & v));
    endfunction

    initial begin
        logic [7:0] r;
        logic [7:0] model [3];
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(AH, r); chk("R1 hold bit", r, 8'h01);
        chk("R1 pin_oe", pin_oe, 24'h0);
        chk("R1 pin_out", pin_out, 24'h0);
        for (int b = 0; b < 3; b++) begin
            rd(AR + b, r);         chk("R1 dir", r, 8'h00);
            rd(AM + 2*b, r);       chk("R1 sel", r, 8'h00);
            rd(AM + 2*b + 1, r);   chk("R1 en", r, 8'h00);
            rd(AD + 2*b + 1, r);   chk("R1 data", r, 8'h00);
        end

        // R2: writes ignored while hold is set
        for (int b = 0; b < 3; b++) begin
            wr(AR + b, 8'hFF); wr(AD + 2*b, 8'hFF); wr(AD + 2*b + 1, 8'hFF);
            wr(AM + 2*b + 1, 8'hA5);
        end
        chk("R2 pin_oe", pin_oe, 24'h0);
        chk("R2 pin_out", pin_out, 24'h0);
        for (int b = 0; b < 3; b++) begin
            rd(AR + b, r);         chk("R2 dir", r, 8'h00);
            rd(AM + 2*b + 1, r);   chk("R2 en", r, 8'h00);
        end

        // R3: release the port
        wr(AH, 8'h00);
        rd(AH, r); chk("R3 release", r, 8'h00);

        // R11: unmapped addresses read zero
        rd('h16, r); chk("R11 unmapped", r, 8'h00);
        rd('h23, r); chk("R11 unmapped", r, 8'h00);
        rd('h7F, r); chk("R11 unmapped", r, 8'h00);

        // R5..R9, R11: uniform and mixed drive-mode sweeps per bank
        for (int b = 0; b < 3; b++) begin
            for (int i = 0; i < 32; i++) begin
                logic [7:0] d, e, s, v;
                if (i < 16) begin
                    d = {8{i[3]}}; e = {8{i[2]}}; s = {8{i[1]}}; v = {8{i[0]}};
                end else begin
                    d = 8'(i * 73 + b * 11 + 5);
                    e = 8'(i * 37 + b * 7 + 1);
                    s = 8'(i * 91 + b * 3 + 9);
                    v = 8'(i * 59 + b * 13 + 2);
                end
                wr(AR + b, d); wr(AM + 2*b, s); wr(AM + 2*b + 1, e);
                wr(AD + 2*b, v); wr(AD + 2*b + 1, 8'hFF);
                chk("R5 R6 R7 R8 pin_oe", pin_oe[b*8 +: 8], exp_oe(d, e, s, v));
                chk("R9 pin_out", pin_out[b*8 +: 8], v);
                rd(AR + b, r);       chk("R11 dir readback", r, d);
                rd(AM + 2*b, r);     chk("R11 sel readback", r, s);
                rd(AM + 2*b + 1, r); chk("R11 en readback", r, e);
            end
        end

        // R4: masked data writes against a bench model
        for (int b = 0; b < 3; b++) begin
            wr(AD + 2*b, 8'h00); wr(AD + 2*b + 1, 8'hFF);
            model[b] = 8'h00;
        end
        for (int i = 0; i < 60; i++) begin
            int b;
            logic [7:0] v, m;
            b = i % 3;
            v = 8'(i * 53 + 7);
            m = (i % 10 == 4) ? 8'h00 : ((i % 10 == 9) ? 8'hFF : 8'(i * 29 + 3));
            wr(AD + 2*b, v); wr(AD + 2*b + 1, m);
            model[b] = (model[b] & ~m) | (v & m);
            rd(AD + 2*b + 1, r); chk("R4 data readback", r, model[b]);
            chk("R4 pin_out", pin_out[b*8 +: 8], model[b]);
        end

        // R10: two-edge input synchroniser, independent of direction
        wr(AR + 0, 8'hFF); wr(AR + 1, 8'h00);
        for (int k = 0; k < 6; k++) begin
            logic [23:0] old_v, new_v;
            old_v = pin_in;
            new_v = 24'(k * 24'h35A7C3 + 24'h0F1E2D);
            @(negedge clk);
            pin_in = new_v;
            for (int b = 0; b < 3; b++) begin
                rd(AD + 2*b, r); chk("R10 before edge", r, old_v[b*8 +: 8]);
            end
            @(negedge clk);
            for (int b = 0; b < 3; b++) begin
                rd(AD + 2*b, r); chk("R10 one edge", r, old_v[b*8 +: 8]);
            end
            @(negedge clk);
            for (int b = 0; b < 3; b++) begin
                rd(AD + 2*b, r); chk("R10 two edges", r, new_v[b*8 +: 8]);
            end
        end

        // R3: re-assert hold clears banks, which stay clear after release
        wr(AR + 2, 8'hFF); wr(AM + 5, 8'h00);
        wr(AH, 8'h01);
        @(negedge clk);
        chk("R3 hold pin_oe", pin_oe, 24'h0);
        chk("R3 hold pin_out", pin_out, 24'h0);
        wr(AH, 8'h00);
        for (int b = 0; b < 3; b++) begin
            rd(AR + b, r);       chk("R3 dir cleared", r, 8'h00);
            rd(AD + 2*b + 1, r); chk("R3 data cleared", r, 8'h00);
            rd(AM + 2*b, r);     chk("R3 sel cleared", r, 8'h00);
        end
        // R4: staging byte cleared by hold, so a bare mask write loads zeros
        wr(AD + 1, 8'hFF);
        rd(AD + 1, r); chk("R4 staged after hold", r, 8'h00);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule